// File: doc/BRIEF.md
# Screen Fetch Address Wrap Adder

This block sits between a video address counter and screen memory. The counter produces a raw 16-bit fetch address that can run past the top of the 32 KB screen region. When it does, the block adds a fixed addend and keeps the low 15 bits of the sum. The fetch then lands back inside the screen buffer, and the picture wraps cleanly from the bottom of the buffer to its top. Addresses that are still inside the region pass through unchanged.

The addend depends on the screen size. Four screen sizes are supported: 8, 10, 16 and 20 KB. Each screen ends at the top of memory, so each needs its own addend, equal to 32 KB minus the screen size. A 2-bit select from an external latch picks the addend. The result is registered and updated only on cycles where the character-clock enable is high. It is held between enables and cleared by reset.

Top module: `scroll_wrap_adder`

## Requirements
- R1: A fetch address from 0x0000 to 0x7FFF appears unchanged on `mem_addr`.
- R2: When the fetch address is above 0x7FFF and `wrap_sel` is 2'b10 (20 KB screen based at 0x3000), the addend is 0x3000. For example, 0x8000 maps to 0x3000.
- R3: When the fetch address is above 0x7FFF and `wrap_sel` is 2'b00 (16 KB screen based at 0x4000), the addend is 0x4000.
- R4: When the fetch address is above 0x7FFF and `wrap_sel` is 2'b11 (10 KB screen based at 0x5800), the addend is 0x5800.
- R5: When the fetch address is above 0x7FFF and `wrap_sel` is 2'b01 (8 KB screen based at 0x6000), the addend is 0x6000.
- R6: The wrapped sum is taken modulo 0x8000. For example, 0xFFFF with select 2'b00 gives 0x3FFF, and 0xFFFF with select 2'b01 gives 0x5FFF.
- R7: `mem_addr` is registered. It shows the result for the inputs sampled at a rising edge where `char_en` is high, one cycle later. It holds its value at edges where `char_en` is low, whatever the fetch address and the select are.
- R8: A synchronous active-high `rst` clears `mem_addr` to 0x0000 at the next rising edge.
- R9: The select is not stored inside the block. A new `wrap_sel` value applies at the very next enabled edge, including between back-to-back enabled edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_en | input | 1 | Character-clock enable; the output updates only when high |
| fetch_addr | input | 16 | Raw display fetch address from the video address counter |
| wrap_sel | input | 2 | Screen-size select from the external latch |
| mem_addr | output | 15 | Registered, wrapped screen memory address |

## Verification
The bench builds the block with its default parameters: a 15-bit memory address, a 16-bit fetch address and the four standard addends. With these values every select code and both sides of the 0x7FFF boundary can be reached directly. The extreme inputs 0x8000 and 0xFFFF expose the modulo-0x8000 truncation for each addend. Enable-low cycles with changing inputs, select changes between adjacent enabled cycles and a reset in mid-run cover the register behaviour.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  // Screen-size select codes; the encoding matches the external latch bits
  typedef enum logic [1:0] {
    SCR_16K = 2'b00,
    SCR_8K  = 2'b01,
    SCR_20K = 2'b10,
    SCR_10K = 2'b11
  } scr_size_e;
endpackage

// File: rtl/wrap_addend_mux.sv
module wrap_addend_mux
  import wrap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] ADD_16K = 'h4000,
  parameter logic [ADDR_W-1:0] ADD_8K  = 'h6000,
  parameter logic [ADDR_W-1:0] ADD_20K = 'h3000,
  parameter logic [ADDR_W-1:0] ADD_10K = 'h5800
) (
  input  logic [1:0]        sel,
  output logic [ADDR_W-1:0] addend
);
  always_comb begin
    unique case (scr_size_e'(sel))
      SCR_16K: addend = ADD_16K;
      SCR_8K:  addend = ADD_8K;
      SCR_20K: addend = ADD_20K;
      SCR_10K: addend = ADD_10K;
      default: addend = ADD_16K;
    endcase
  end
endmodule

// File: rtl/wrap_fold.sv
module wrap_fold #(
  parameter int ADDR_W = 15,
  parameter int IN_W   = 16
) (
  input  logic [IN_W-1:0]   raw,
  input  logic [ADDR_W-1:0] addend,
  output logic [ADDR_W-1:0] folded,
  output logic              over_top
);
  logic [ADDR_W-1:0] low_part;
  assign low_part = raw[ADDR_W-1:0];

  generate
    if (IN_W > ADDR_W) begin : g_over
      assign over_top = |raw[IN_W-1:ADDR_W];
    end else begin : g_no_over
      assign over_top = 1'b0;
    end
  endgenerate

  // The sum is ADDR_W bits wide, so the carry out of the region drops off
  always_comb begin
    if (over_top) folded = low_part + addend;
    else          folded = low_part;
  end
endmodule

// File: rtl/wrap_out_reg.sv
module wrap_out_reg #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  // R8: reset clears the output register
  assert_reset_clear_R8: assert property (@(posedge clk) rst |=> (q == '0));
  // R7: the register holds between enables
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));
endmodule

// File: rtl/scroll_wrap_adder.sv
module scroll_wrap_adder #(
  parameter int ADDR_W = 15,
  parameter int IN_W   = 16,
  parameter logic [ADDR_W-1:0] ADD_16K = 'h4000,
  parameter logic [ADDR_W-1:0] ADD_8K  = 'h6000,
  parameter logic [ADDR_W-1:0] ADD_20K = 'h3000,
  parameter logic [ADDR_W-1:0] ADD_10K = 'h5800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_en,
  input  logic [IN_W-1:0]   fetch_addr,
  input  logic [1:0]        wrap_sel,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam logic [IN_W-1:0] TOP_ADDR = IN_W'((1 << ADDR_W) - 1);

  logic [ADDR_W-1:0] addend;
  logic [ADDR_W-1:0] folded;
  logic              over_top;

  wrap_addend_mux #(
    .ADDR_W(ADDR_W), .ADD_16K(ADD_16K), .ADD_8K(ADD_8K),
    .ADD_20K(ADD_20K), .ADD_10K(ADD_10K)
  ) u_mux (
    .sel(wrap_sel), .addend(addend)
  );

  wrap_fold #(.ADDR_W(ADDR_W), .IN_W(IN_W)) u_fold (
    .raw(fetch_addr), .addend(addend), .folded(folded), .over_top(over_top)
  );

  wrap_out_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk(clk), .rst(rst), .en(char_en), .d(folded), .q(mem_addr)
  );

  // R1: in-range addresses pass straight through
  assert_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (char_en && fetch_addr <= TOP_ADDR) |=>
      (mem_addr == $past(fetch_addr[ADDR_W-1:0])));
  // R2, R6, R9: 20 KB screen
  assert_wrap20_R2: assert property (@(posedge clk) disable iff (rst)
    (char_en && fetch_addr > TOP_ADDR && wrap_sel == 2'b10) |=>
      (mem_addr == ADDR_W'($past(fetch_addr[ADDR_W-1:0]) + ADD_20K)));
  // R3, R6, R9: 16 KB screen
  assert_wrap16_R3: assert property (@(posedge clk) disable iff (rst)
    (char_en && fetch_addr > TOP_ADDR && wrap_sel == 2'b00) |=>
      (mem_addr == ADDR_W'($past(fetch_addr[ADDR_W-1:0]) + ADD_16K)));
  // R4, R6, R9: 10 KB screen
  assert_wrap10_R4: assert property (@(posedge clk) disable iff (rst)
    (char_en && fetch_addr > TOP_ADDR && wrap_sel == 2'b11) |=>
      (mem_addr == ADDR_W'($past(fetch_addr[ADDR_W-1:0]) + ADD_10K)));
  // R5, R6, R9: 8 KB screen
  assert_wrap8_R5: assert property (@(posedge clk) disable iff (rst)
    (char_en && fetch_addr > TOP_ADDR && wrap_sel == 2'b01) |=>
      (mem_addr == ADDR_W'($past(fetch_addr[ADDR_W-1:0]) + ADD_8K)));
endmodule

// File: tb/sim_scroll_wrap_adder.sv
module sim_scroll_wrap_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        char_en = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [1:0]  wrap_sel = '0;
  logic [14:0] mem_addr;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [14:0] exp_q[$];
  string       tag_q[$];
  logic [14:0] model_state = '0;

  always #5 clk = ~clk;

  scroll_wrap_adder u0 (
    .clk(clk), .rst(rst), .char_en(char_en),
    .fetch_addr(fetch_addr), .wrap_sel(wrap_sel), .mem_addr(mem_addr)
  );

  // Reference model, written from the requirements
  function automatic logic [14:0] model(input logic [15:0] a, input logic [1:0] s);
    logic [15:0] add;
    case (s)
      2'b00: add = 16'h4000;   // R3
      2'b01: add = 16'h6000;   // R5
      2'b10: add = 16'h3000;   // R2
      default: add = 16'h5800; // R4
    endcase
    if (a > 16'h7FFF) return 15'((a + add) & 16'h7FFF); // R6
    return a[14:0];                                     // R1
  endfunction

  // Driver: one edge of stimulus, expected value pushed to the scoreboard
  task automatic drive(input logic [15:0] a, input logic [1:0] s,
                       input logic en, input string tag);
    @(negedge clk);
    rst = 1'b0; fetch_addr = a; wrap_sel = s; char_en = en;
    if (en) model_state = model(a, s);
    exp_q.push_back(model_state);
    tag_q.push_back(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; char_en = 1'b1; fetch_addr = 16'hFFFF;
    model_state = '0;
    exp_q.push_back(model_state);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      automatic logic [14:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      compared++;
      if (mem_addr !== e) begin
        mismatched++;
        $display("FAIL %s: mem_addr=%h expected=%h", t, mem_addr, e);
      end
    end
  end

  initial begin
    do_reset("R8 initial reset");
    do_reset("R8 reset held");
    drive(16'h0000, 2'b00, 1'b1, "R1 zero");
    drive(16'h1234, 2'b10, 1'b1, "R1 mid");
    drive(16'h7FFF, 2'b01, 1'b1, "R1 top edge");
    drive(16'h8000, 2'b10, 1'b1, "R2 0x8000");
    drive(16'h9ABC, 2'b10, 1'b1, "R2 mid");
    drive(16'h8000, 2'b00, 1'b1, "R3 0x8000");
    drive(16'hA001, 2'b00, 1'b1, "R3 mid");
    drive(16'h8000, 2'b11, 1'b1, "R4 0x8000");
    drive(16'h8123, 2'b11, 1'b1, "R4 mid");
    drive(16'h8000, 2'b01, 1'b1, "R5 0x8000");
    drive(16'h8FFF, 2'b01, 1'b1, "R5 mid");
    drive(16'hFFFF, 2'b00, 1'b1, "R6 0xFFFF sel00");
    drive(16'hFFFF, 2'b01, 1'b1, "R6 0xFFFF sel01");
    drive(16'hFFFF, 2'b11, 1'b1, "R6 0xFFFF sel11");
    drive(16'hC000, 2'b10, 1'b1, "R6 0xC000 sel10");
    drive(16'h0042, 2'b00, 1'b0, "R7 hold low addr");
    drive(16'hE000, 2'b01, 1'b0, "R7 hold wrap addr");
    drive(16'h8000, 2'b11, 1'b0, "R7 hold sel change");
    drive(16'h0100, 2'b00, 1'b1, "R7 update after hold");
    drive(16'h8100, 2'b00, 1'b1, "R9 sel 00");
    drive(16'h8100, 2'b01, 1'b1, "R9 sel 01");
    drive(16'h8100, 2'b10, 1'b1, "R9 sel 10");
    drive(16'h8100, 2'b11, 1'b1, "R9 sel 11");
    do_reset("R8 mid-run reset");
    drive(16'h7000, 2'b10, 1'b0, "R8 hold after reset");
    for (int i = 0; i < 200; i++) begin
      automatic logic [15:0] a = 16'(i * 16'h1357 + 16'h0F0F);
      drive(a, 2'(i), 1'(i % 5 != 0), "R7 sweep");
    end
    drive(16'h0000, 2'b00, 1'b0, "R7 final");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule